// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel. A start pulse gives it a pointer to a descriptor in memory. The descriptor is four 32-bit words. The channel reads the descriptor and copies a block of bytes from a source address to a target address. The copy runs in bursts over a word-wide memory master port. Each burst reads all of its beats into a local buffer first, and only then writes them out. This means the source and target may use different byte lanes.

Descriptors can be chained through their next-pointer word. A peripheral request level can pace the copy when the command word makes the source or the target the flow controller. When that request goes away after a burst, the channel raises an end-of-receive flag. Depending on two enable inputs, it then stops, jumps to the next descriptor, or waits for the request to return.

The surrounding logic starts the channel, supplies the compare-status and mode inputs, and reads the sticky start, end, stop and end-of-receive flags. It also reads the remaining byte count.

Top module: `dma_chain_engine`

## Requirements
- R1: The descriptor fetch address is the pointer with its low 4 bits forced to zero. It is raised by 32 when pointer bit 1 and `cmp_st_i` are both high. The four words are read from consecutive word addresses in this order: next pointer, source, target, command.
- R2: When a descriptor loads, the source address has its low 2 bits cleared if command bit 29 (source paces) is set. The target address has its low 2 bits cleared if command bit 28 (target paces) is set.
- R3: `start_flag_o` sets when a descriptor loads with command bit 22 set.
- R4: Command bits 15:14 give the beat width: code 1 is 1 byte, code 2 is 2 bytes, code 3 is 4 bytes. A narrow beat uses the byte lanes chosen by the low address bits on both data and byte enables, in little-endian order.
- R5: Each burst moves min(remaining, 4 << bits 17:16) bytes. All of its reads come before all of its writes. Source and target step by the width when bits 31 and 30 are set, and stay fixed otherwise.
- R6: After each burst, `rem_len_o` (command bits 12:0) holds the bytes still to move.
- R7: When the length reaches zero, `end_flag_o` sets if command bit 21 is set. The channel stops if `nofetch_i` is high, or next-pointer bit 0 is set, or `eor_stop_en_i` is high. Otherwise it fetches the descriptor at the next pointer.
- R8: A flow-controlled channel starts no burst while `dreq_i` is low.
- R9: If `dreq_i` is low after a flow-controlled burst, `eor_flag_o` sets. The channel then stops if `eor_stop_en_i` is high. Otherwise it fetches the next descriptor if `eor_jump_en_i` is high and `nofetch_i` is low.
- R10: Width code 0 is reserved. Such a descriptor stops the channel with no data access.
- R11: Each accepted request (`mem_req_o` and `mem_ready_i`) is one beat. Address, write enable, data and byte enables stay stable while a request waits for ready.
- R12: After reset, `busy_o` is low, `stop_flag_o` is high, the other flags are low and no request is issued. A start pulse clears all four flags. Stopping sets `stop_flag_o` and drops `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| desc_ptr_i | input | 32 | First descriptor pointer |
| cmp_st_i | input | 1 | Compare status, selects the branch descriptor |
| nofetch_i | input | 1 | Forbid following descriptor links |
| eor_stop_en_i | input | 1 | Stop on end of receive |
| eor_jump_en_i | input | 1 | Jump to next descriptor on end of receive |
| dreq_i | input | 1 | Peripheral request level |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write enable |
| mem_addr_o | output | 32 | Byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, word aligned |
| mem_ready_i | input | 1 | Beat accepted |
| busy_o | output | 1 | Channel running |
| start_flag_o | output | 1 | Start flag |
| end_flag_o | output | 1 | End flag |
| stop_flag_o | output | 1 | Stopped flag |
| eor_flag_o | output | 1 | End-of-receive flag |
| rem_len_o | output | 13 | Remaining byte count |

## Verification
A vector table varies the beat width, the burst code, the length, the increment flags and the sub-word address offsets. A byte-level model predicts the target image, so these cases tell apart lane placement, burst splitting and fixed-address behaviour. Note that a fixed source repeats a single value, while a fixed target keeps only the last beat.

Directed runs cover the following:
- both branch choices of the fetch address;
- a chain run with link following allowed, and the same chain with `nofetch_i` high;
- a request drop in the middle of a transfer with the stop rule, and again with the jump rule;
- a paced source whose address is unaligned;
- a reserved width code.

These separate stop decisions from chaining decisions.

// File: rtl/dma_chain_pkg.sv
// Shared definitions for the descriptor-chained DMA channel.
// Assumes a 32-bit word-wide memory port and byte addressing.
package dma_chain_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_EVAL, ST_READ, ST_WRITE, ST_POST
    } dma_state_e;

    // Command word bit positions that the channel decodes
    localparam int CB_INC_SRC  = 31;
    localparam int CB_INC_DST  = 30;
    localparam int CB_FLOW_SRC = 29;
    localparam int CB_FLOW_DST = 28;
    localparam int CB_START_IE = 22;
    localparam int CB_END_IE   = 21;
    localparam int CB_BURST_LO = 16;
    localparam int CB_WIDTH_LO = 14;
endpackage

// File: rtl/dma_cmd_decode.sv
// Command word decoder: unpacks length, width, burst and mode bits.
// Assumes width code 0 is reserved and burst size is 4 << code bytes.
module dma_cmd_decode
    import dma_chain_pkg::*;
#(
    parameter int LEN_W = 13,
    parameter int CNT_W = 6
) (
    input  logic [31:0]      cmd_i,
    output logic [LEN_W-1:0] len_o,
    output logic [2:0]       wid_o,
    output logic             wid_rsvd_o,
    output logic [CNT_W-1:0] burst_o,
    output logic             inc_src_o,
    output logic             inc_dst_o,
    output logic             flow_o,
    output logic             start_ie_o,
    output logic             end_ie_o
);
    logic [1:0] wcode;
    logic [1:0] bcode;

    assign wcode = cmd_i[CB_WIDTH_LO +: 2];
    assign bcode = cmd_i[CB_BURST_LO +: 2];

    // Width code to byte count
    always_comb begin
        case (wcode)
            2'd1:    wid_o = 3'd1;
            2'd2:    wid_o = 3'd2;
            2'd3:    wid_o = 3'd4;
            default: wid_o = 3'd0;
        endcase
    end

    assign wid_rsvd_o = (wcode == 2'd0);
    assign burst_o    = CNT_W'(4) << bcode;
    assign len_o      = cmd_i[LEN_W-1:0];
    assign inc_src_o  = cmd_i[CB_INC_SRC];
    assign inc_dst_o  = cmd_i[CB_INC_DST];
    assign flow_o     = cmd_i[CB_FLOW_SRC] | cmd_i[CB_FLOW_DST];
    assign start_ie_o = cmd_i[CB_START_IE];
    assign end_ie_o   = cmd_i[CB_END_IE];
endmodule

// File: rtl/dma_lane_align.sv
// Byte-lane steering for beats of 1, 2 or 4 bytes on a 32-bit port.
// Assumes little-endian lanes and naturally aligned narrow beats.
module dma_lane_align (
    input  logic [1:0]  addr_lo_i,
    input  logic [2:0]  wid_i,
    input  logic [31:0] rd_word_i,
    input  logic [31:0] beat_i,
    output logic [31:0] rd_beat_o,
    output logic [31:0] wr_word_o,
    output logic [3:0]  be_o
);
    logic [4:0]  sh;
    logic [31:0] mask;
    logic [3:0]  base_be;

    // Lane shift, value mask and base enables from the beat width
    always_comb begin
        case (wid_i)
            3'd1: begin sh = {addr_lo_i, 3'b000};     mask = 32'h0000_00FF; base_be = 4'b0001; end
            3'd2: begin sh = {addr_lo_i[1], 4'b0000}; mask = 32'h0000_FFFF; base_be = 4'b0011; end
            default: begin sh = 5'd0;                 mask = 32'hFFFF_FFFF; base_be = 4'b1111; end
        endcase
    end

    assign rd_beat_o = (rd_word_i >> sh) & mask;
    assign wr_word_o = (beat_i & mask) << sh;
    assign be_o      = base_be << sh[4:3];
endmodule

// File: rtl/dma_beat_buf.sv
// Burst holding buffer: one right-aligned entry per beat.
// Assumes writes during the read phase and reads during the write phase.
module dma_beat_buf #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [31:0]      wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [31:0]      rd_data_o
);
    logic [31:0] store [DEPTH];

    // Capture a beat read from the source
    always_ff @(posedge clk) begin
        if (wr_en_i) store[wr_idx_i] <= wr_data_i;
    end

    assign rd_data_o = store[rd_idx_i];
endmodule

// File: rtl/dma_chain_engine.sv
// Single DMA channel. It fetches four-word descriptors, copies data in
// read-then-write bursts, follows links and obeys request pacing.
// Assumes a memory slave that accepts one beat per cycle of req && ready
// and returns word-aligned read data in the same cycle.
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int LEN_W   = 13,
    parameter int BCODE_W = 2,
    localparam int MAX_BURST = 4 << ((1 << BCODE_W) - 1),
    localparam int CNT_W     = $clog2(MAX_BURST) + 1,
    localparam int IDX_W     = $clog2(MAX_BURST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [31:0]      desc_ptr_i,
    input  logic             cmp_st_i,
    input  logic             nofetch_i,
    input  logic             eor_stop_en_i,
    input  logic             eor_jump_en_i,
    input  logic             dreq_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [31:0]      mem_addr_o,
    output logic [3:0]       mem_be_o,
    output logic [31:0]      mem_wdata_o,
    input  logic [31:0]      mem_rdata_i,
    input  logic             mem_ready_i,
    output logic             busy_o,
    output logic             start_flag_o,
    output logic             end_flag_o,
    output logic             stop_flag_o,
    output logic             eor_flag_o,
    output logic [LEN_W-1:0] rem_len_o
);
    dma_state_e       st_q;
    logic [31:0]      fbase_q, nxt_q, src_q, dst_q, cmd_q;
    logic [1:0]       fidx_q;
    logic [CNT_W-1:0] beat_q, nbeats_q, bbytes_q;

    logic [LEN_W-1:0] len;
    logic [2:0]       wid;
    logic             wid_rsvd, inc_src, inc_dst, flow, start_ie, end_ie;
    logic [CNT_W-1:0] burst, bytes, nbeats;
    logic [LEN_W-1:0] newlen;
    logic             hs;
    logic [31:0]      rd_beat, wr_word, buf_rd;
    logic [3:0]       lane_be;
    logic [1:0]       lane_lo;

    function automatic logic [31:0] fetch_addr(input logic [31:0] p, input logic c);
        return {p[31:4], 4'h0} + ((p[1] && c) ? 32'd32 : 32'd0);
    endfunction

    dma_cmd_decode #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dec_i (
        .cmd_i(cmd_q), .len_o(len), .wid_o(wid), .wid_rsvd_o(wid_rsvd),
        .burst_o(burst), .inc_src_o(inc_src), .inc_dst_o(inc_dst),
        .flow_o(flow), .start_ie_o(start_ie), .end_ie_o(end_ie)
    );

    assign lane_lo = (st_q == ST_WRITE) ? dst_q[1:0] : src_q[1:0];

    dma_lane_align lane_i (
        .addr_lo_i(lane_lo), .wid_i(wid), .rd_word_i(mem_rdata_i),
        .beat_i(buf_rd), .rd_beat_o(rd_beat), .wr_word_o(wr_word), .be_o(lane_be)
    );

    dma_beat_buf #(.DEPTH(MAX_BURST)) buf_i (
        .clk(clk), .wr_en_i(st_q == ST_READ && hs), .wr_idx_i(beat_q[IDX_W-1:0]),
        .wr_data_i(rd_beat), .rd_idx_i(beat_q[IDX_W-1:0]), .rd_data_o(buf_rd)
    );

    // Burst size and beat count for the next burst
    always_comb begin
        bytes = (len < LEN_W'(burst)) ? CNT_W'(len) : burst;
        case (wid)
            3'd1:    nbeats = bytes;
            3'd2:    nbeats = (bytes + CNT_W'(1)) >> 1;
            default: nbeats = (bytes + CNT_W'(3)) >> 2;
        endcase
        newlen = len - LEN_W'(bbytes_q);
    end

    // Memory port drive from the current phase
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = src_q;
        mem_be_o    = lane_be;
        mem_wdata_o = wr_word;
        case (st_q)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = fbase_q + {28'd0, fidx_q, 2'b00};
                mem_be_o   = 4'hF;
            end
            ST_READ:  mem_req_o = 1'b1;
            ST_WRITE: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = dst_q;
            end
            default: ;
        endcase
    end

    assign hs        = mem_req_o & mem_ready_i;
    assign busy_o    = (st_q != ST_IDLE);
    assign rem_len_o = cmd_q[LEN_W-1:0];

    // Channel sequencer: fetch, evaluate, read burst, write burst, post-check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            fbase_q <= '0; nxt_q <= '0; src_q <= '0; dst_q <= '0; cmd_q <= '0;
            fidx_q <= '0; beat_q <= '0; nbeats_q <= '0; bbytes_q <= '0;
            start_flag_o <= 1'b0; end_flag_o <= 1'b0;
            stop_flag_o  <= 1'b1; eor_flag_o <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (start_i) begin
                    fbase_q <= fetch_addr(desc_ptr_i, cmp_st_i);
                    fidx_q  <= '0;
                    start_flag_o <= 1'b0; end_flag_o <= 1'b0;
                    stop_flag_o  <= 1'b0; eor_flag_o <= 1'b0;
                    st_q <= ST_FETCH;
                end
                ST_FETCH: if (hs) begin
                    fidx_q <= fidx_q + 2'd1;
                    case (fidx_q)
                        2'd0: nxt_q <= mem_rdata_i;
                        2'd1: src_q <= mem_rdata_i;
                        2'd2: dst_q <= mem_rdata_i;
                        default: begin
                            cmd_q <= mem_rdata_i;
                            if (mem_rdata_i[CB_FLOW_SRC]) src_q[1:0] <= 2'b00;
                            if (mem_rdata_i[CB_FLOW_DST]) dst_q[1:0] <= 2'b00;
                            if (mem_rdata_i[CB_START_IE]) start_flag_o <= 1'b1;
                            st_q <= ST_EVAL;
                        end
                    endcase
                end
                ST_EVAL: begin
                    if (wid_rsvd) begin
                        stop_flag_o <= 1'b1;
                        st_q <= ST_IDLE;
                    end else if (len == '0) begin
                        if (end_ie) end_flag_o <= 1'b1;
                        if (nofetch_i || nxt_q[0] || eor_stop_en_i) begin
                            stop_flag_o <= 1'b1;
                            st_q <= ST_IDLE;
                        end else begin
                            fbase_q <= fetch_addr(nxt_q, cmp_st_i);
                            fidx_q  <= '0;
                            st_q <= ST_FETCH;
                        end
                    end else if (!(flow && !dreq_i)) begin
                        bbytes_q <= bytes;
                        nbeats_q <= nbeats;
                        beat_q   <= '0;
                        st_q <= ST_READ;
                    end
                end
                ST_READ: if (hs) begin
                    if (inc_src) src_q <= src_q + {29'd0, wid};
                    if (beat_q == nbeats_q - CNT_W'(1)) begin
                        beat_q <= '0;
                        st_q <= ST_WRITE;
                    end else beat_q <= beat_q + CNT_W'(1);
                end
                ST_WRITE: if (hs) begin
                    if (inc_dst) dst_q <= dst_q + {29'd0, wid};
                    if (beat_q == nbeats_q - CNT_W'(1)) st_q <= ST_POST;
                    else beat_q <= beat_q + CNT_W'(1);
                end
                ST_POST: begin
                    cmd_q[LEN_W-1:0] <= newlen;
                    st_q <= ST_EVAL;
                    if (flow && !dreq_i) begin
                        eor_flag_o <= 1'b1;
                        if (eor_stop_en_i) begin
                            if (newlen == '0 && end_ie) end_flag_o <= 1'b1;
                            stop_flag_o <= 1'b1;
                            st_q <= ST_IDLE;
                        end else if (eor_jump_en_i && !nofetch_i) begin
                            fbase_q <= fetch_addr(nxt_q, cmp_st_i);
                            fidx_q  <= '0;
                            st_q <= ST_FETCH;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R11: a waiting request keeps its address, direction, data and enables
    a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
        $stable(mem_we_o) && $stable(mem_wdata_o) && $stable(mem_be_o));

    // R8: a paced channel with request low issues no access next cycle
    a_r8_flow_wait: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_EVAL && flow && !dreq_i && len != '0 && !wid_rsvd |=> !mem_req_o);

    // R10: reserved width code ends the run at once
    a_r10_rsvd_stop: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_EVAL && wid_rsvd |=> !busy_o && stop_flag_o);

    // R6: the remaining count shrinks after every burst
    a_r6_len_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_POST |=> rem_len_o < $past(rem_len_o));

    // R12: dropping busy always leaves the stopped flag set
    a_r12_stop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> stop_flag_o);
endmodule

// File: tb/dma_chain_engine_tb_top.sv
module dma_chain_engine_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start_i = 0, cmp_st_i = 0, nofetch_i = 0;
    logic        eor_stop_en_i = 0, eor_jump_en_i = 0, dreq_i = 0;
    logic [31:0] desc_ptr_i = 0;
    logic        mem_req_o, mem_we_o, mem_ready_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [3:0]  mem_be_o;
    logic        busy_o, start_flag_o, end_flag_o, stop_flag_o, eor_flag_o;
    logic [12:0] rem_len_o;

    dma_chain_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
        .cmp_st_i(cmp_st_i), .nofetch_i(nofetch_i), .eor_stop_en_i(eor_stop_en_i),
        .eor_jump_en_i(eor_jump_en_i), .dreq_i(dreq_i), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
        .busy_o(busy_o), .start_flag_o(start_flag_o), .end_flag_o(end_flag_o),
        .stop_flag_o(stop_flag_o), .eor_flag_o(eor_flag_o), .rem_len_o(rem_len_o)
    );

    // Memory model: 1 KiB of bytes, ready stalls one cycle in four
    logic [7:0]  mem8 [0:1023];
    logic [7:0]  exp8 [0:1023];
    logic [1:0]  rcnt = 0;
    int          acc_cnt = 0;
    int          hold_err = 0;
    logic [31:0] addr_log [0:7];
    logic        wait_q = 0;
    logic [31:0] wait_addr = 0;
    logic [31:0] wait_data = 0;

    assign mem_ready_i = (rcnt != 2'd1);
    assign mem_rdata_i = {mem8[{mem_addr_o[9:2], 2'd3}], mem8[{mem_addr_o[9:2], 2'd2}],
                          mem8[{mem_addr_o[9:2], 2'd1}], mem8[{mem_addr_o[9:2], 2'd0}]};

    always @(posedge clk) begin
        rcnt <= rcnt + 2'd1;
        if (mem_req_o && mem_ready_i) begin
            addr_log[acc_cnt % 8] <= mem_addr_o;
            acc_cnt <= acc_cnt + 1;
            if (mem_we_o)
                for (int b = 0; b < 4; b++)
                    if (mem_be_o[b]) mem8[{mem_addr_o[9:2], 2'(b)}] <= mem_wdata_o[8*b +: 8];
        end
        if (wait_q && (mem_addr_o !== wait_addr || (mem_we_o && mem_wdata_o !== wait_data)))
            hold_err <= hold_err + 1;
        wait_q    <= mem_req_o && !mem_ready_i;
        wait_addr <= mem_addr_o;
        wait_data <= mem_wdata_o;
    end

    int nchk = 0, nerr = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) mem8[a + b] = v[8*b +: 8];
    endtask

    function automatic logic [31:0] get_word(input int a);
        return {mem8[a+3], mem8[a+2], mem8[a+1], mem8[a]};
    endfunction

    task automatic init_image();
        for (int i = 0; i < 1024; i++) mem8[i] = 8'(i * 7 + 3);
        for (int i = 512; i < 768; i++) mem8[i] = 8'h00;
        for (int i = 0; i < 1024; i++) exp8[i] = mem8[i];
    endtask

    task automatic run_chan(input logic [31:0] ptr);
        @(negedge clk);
        desc_ptr_i = ptr;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 3000 && busy_o; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_cmd(input bit is, input bit it, input bit fs,
        input bit ft, input bit sie, input bit eie, input logic [1:0] bc,
        input logic [1:0] wc, input logic [12:0] len);
        return {is, it, fs, ft, 5'd0, sie, eie, 3'd0, bc, wc, 1'b0, len};
    endfunction

    typedef struct packed {
        logic [1:0]  wcode;
        logic [1:0]  bcode;
        logic [12:0] len;
        logic        is, it;
        logic [1:0]  soff, doff;
        logic        sie, eie;
    } vec_t;

    // R4/R5 vectors: width, burst, length, increments, lane offsets, flag enables
    localparam vec_t VECS [0:4] = '{
        '{wcode: 2'd3, bcode: 2'd0, len: 13'd16, is: 1'b1, it: 1'b1, soff: 2'd0, doff: 2'd0, sie: 1'b1, eie: 1'b1},
        '{wcode: 2'd1, bcode: 2'd1, len: 13'd13, is: 1'b1, it: 1'b1, soff: 2'd1, doff: 2'd2, sie: 1'b0, eie: 1'b1},
        '{wcode: 2'd2, bcode: 2'd3, len: 13'd36, is: 1'b1, it: 1'b1, soff: 2'd2, doff: 2'd0, sie: 1'b1, eie: 1'b0},
        '{wcode: 2'd3, bcode: 2'd2, len: 13'd12, is: 1'b0, it: 1'b1, soff: 2'd0, doff: 2'd0, sie: 1'b0, eie: 1'b0},
        '{wcode: 2'd1, bcode: 2'd0, len: 13'd5,  is: 1'b1, it: 1'b0, soff: 2'd3, doff: 2'd1, sie: 1'b0, eie: 1'b1}
    };

    initial begin
        int mark, w, s, d, mism;
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 busy after reset", busy_o, 0);
        chk("R12 stop flag after reset", stop_flag_o, 1);
        chk("R12 other flags after reset", {start_flag_o, end_flag_o, eor_flag_o}, 0);
        chk("R12 no request after reset", mem_req_o, 0);

        // R4 R5 R3 R6 R7: table walk
        for (int k = 0; k < 5; k++) begin
            v = VECS[k];
            init_image();
            put_word(0, 32'h1);
            put_word(4, 32'h100 + v.soff);
            put_word(8, 32'h200 + v.doff);
            put_word(12, mk_cmd(v.is, v.it, 0, 0, v.sie, v.eie, v.bcode, v.wcode, v.len));
            w = 1 << (v.wcode - 1);
            for (int b = 0; b < v.len / w; b++) begin
                s = 32'h100 + v.soff + (v.is ? b * w : 0);
                d = 32'h200 + v.doff + (v.it ? b * w : 0);
                for (int j = 0; j < w; j++) exp8[d + j] = mem8[s + j];
            end
            run_chan(32'h0);
            mism = 0;
            for (int i = 512; i < 768; i++) if (mem8[i] !== exp8[i]) mism++;
            chk($sformatf("R4 R5 vector %0d target image mismatches", k), mism, 0);
            chk($sformatf("R3 vector %0d start flag", k), start_flag_o, v.sie);
            chk($sformatf("R7 vector %0d end flag", k), end_flag_o, v.eie);
            chk($sformatf("R6 vector %0d remaining length", k), rem_len_o, 0);
            chk($sformatf("R12 vector %0d stopped", k), {busy_o, stop_flag_o}, 2'b01);
        end

        // R1 branch fetch address
        init_image();
        put_word(32'h40, 32'h1); put_word(32'h44, 32'h100); put_word(32'h48, 32'h240);
        put_word(32'h4C, mk_cmd(1, 1, 0, 0, 0, 0, 0, 3, 4));
        put_word(32'h60, 32'h1); put_word(32'h64, 32'h100); put_word(32'h68, 32'h200);
        put_word(32'h6C, mk_cmd(1, 1, 0, 0, 0, 0, 0, 3, 4));
        cmp_st_i = 1'b1;
        mark = acc_cnt;
        run_chan(32'h4E);
        chk("R1 branch taken fetch address", addr_log[mark % 8], 32'h60);
        chk("R1 branch taken target word", get_word(32'h200), exp8[32'h100] | (32'(exp8[32'h101]) << 8) | (32'(exp8[32'h102]) << 16) | (32'(exp8[32'h103]) << 24));
        cmp_st_i = 1'b0;
        mark = acc_cnt;
        run_chan(32'h4E);
        chk("R1 branch not taken fetch address", addr_log[mark % 8], 32'h40);

        // R2 paced source address alignment, R8 wait while request low
        init_image();
        put_word(0, 32'h1); put_word(4, 32'h103); put_word(8, 32'h200);
        put_word(12, mk_cmd(1, 1, 1, 0, 0, 0, 0, 3, 4));
        dreq_i = 1'b0;
        mark = acc_cnt;
        @(negedge clk); start_i = 1'b1; desc_ptr_i = 0;
        @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 busy while request low", busy_o, 1);
        chk("R8 only descriptor accesses while request low", acc_cnt - mark, 4);
        dreq_i = 1'b1;
        for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
        chk("R2 source low bits cleared", get_word(32'h200), get_word(32'h100));
        chk("R9 no end-of-receive with request high", eor_flag_o, 0);

        // R9 end-of-receive stop, R6 remaining count
        init_image();
        put_word(0, 32'h1); put_word(4, 32'h100); put_word(8, 32'h200);
        put_word(12, mk_cmd(1, 1, 0, 1, 0, 1, 0, 3, 40));
        eor_stop_en_i = 1'b1; dreq_i = 1'b1;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 200 && !(mem_req_o && mem_we_o); i++) @(negedge clk);
        dreq_i = 1'b0;
        for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
        chk("R9 eor flag on request drop", eor_flag_o, 1);
        chk("R6 remaining after one burst", rem_len_o, 36);
        chk("R9 eor stop ends run", {busy_o, stop_flag_o}, 2'b01);
        chk("R7 no end flag with bytes left", end_flag_o, 0);
        eor_stop_en_i = 1'b0;

        // R9 end-of-receive jump to next descriptor
        init_image();
        put_word(0, 32'h80); put_word(4, 32'h100); put_word(8, 32'h200);
        put_word(12, mk_cmd(1, 1, 0, 1, 0, 0, 0, 3, 40));
        put_word(32'h80, 32'h1); put_word(32'h84, 32'h140); put_word(32'h88, 32'h280);
        put_word(32'h8C, mk_cmd(1, 1, 0, 0, 0, 1, 0, 3, 8));
        eor_jump_en_i = 1'b1; dreq_i = 1'b1;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 200 && !(mem_req_o && mem_we_o); i++) @(negedge clk);
        dreq_i = 1'b0;
        for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
        chk("R9 jump loaded next descriptor data", get_word(32'h284), get_word(32'h144));
        chk("R9 jump keeps eor flag", eor_flag_o, 1);
        chk("R7 jumped descriptor end flag", end_flag_o, 1);
        eor_jump_en_i = 1'b0;

        // R7 chain follow, then the same chain with link following forbidden
        for (int n = 0; n < 2; n++) begin
            init_image();
            put_word(0, 32'h80); put_word(4, 32'h100); put_word(8, 32'h200);
            put_word(12, mk_cmd(1, 1, 0, 0, 0, 0, 0, 3, 4));
            put_word(32'h80, 32'h1); put_word(32'h84, 32'h104); put_word(32'h88, 32'h204);
            put_word(32'h8C, mk_cmd(1, 1, 0, 0, 0, 0, 0, 3, 4));
            nofetch_i = (n == 1);
            run_chan(32'h0);
            chk($sformatf("R7 chain pass %0d first word", n), get_word(32'h200), get_word(32'h100));
            chk($sformatf("R7 chain pass %0d second word", n), get_word(32'h204),
                (n == 0) ? get_word(32'h104) : 32'h0);
        end
        nofetch_i = 1'b0;

        // R10 reserved width code
        init_image();
        put_word(0, 32'h1); put_word(4, 32'h100); put_word(8, 32'h200);
        put_word(12, mk_cmd(1, 1, 0, 0, 0, 1, 0, 0, 8));
        mark = acc_cnt;
        run_chan(32'h0);
        chk("R10 only descriptor accesses", acc_cnt - mark, 4);
        chk("R10 target untouched", get_word(32'h200), 32'h0);
        chk("R10 stopped without end flag", {busy_o, stop_flag_o, end_flag_o}, 3'b010);

        // R11 stability across waits
        chk("R11 request held stable until ready", hold_err, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule